// File: doc/BRIEF.md
# One-Wire Device-Side Bit-Slot Responder

This block sits on the device end of a one-wire bus and serves single bit slots that the bus master starts. The raw bus level enters through a synchronizer. The block treats every falling edge seen while it is idle as the start of a slot. A direction input chosen by upstream logic says what kind of slot comes next. When the master is writing, the block waits a fixed number of microseconds after the edge and reads the bus level. It then returns that level as a received bit, together with a one-cycle strobe. When the master is reading, the block takes the bit offered by upstream logic at the edge and acknowledges it with a one-cycle pulse. For a 0 it pulls the bus low for a bounded time. For a 1 it leaves the bus alone.

All slot timing counts microseconds from a tick divided down from the system clock by a parameter. The tick divider and the microsecond counter both restart on the slot's own edge, so the sample point and the drive length are exact cycle counts. After a slot's timed action the block waits for the bus to read high before it accepts another edge. Reset and presence handling, command decoding and data storage belong to the surrounding logic.

Top module: `owr_slot_resp`

## Requirements
- R1: While reset is asserted, `bus_pull`, `rx_valid` and `tx_taken` are 0, and reset taking effect in the middle of a driven 0 releases the bus at once.
- R2: In a write slot, `rx_valid` pulses high for exactly one cycle. It is registered SAMPLE_US microseconds (SAMPLE_US x CLK_PER_US cycles) after the clock edge at which the synchronized falling edge is detected. That detection edge is the third rising clock edge after the raw bus falls.
- R3: The bus level at the sample point decides `rx_bit`: high gives `rx_bit` = 1 and low gives `rx_bit` = 0.
- R4: In a read slot with `tx_bit` = 0, `bus_pull` (1 = pull the bus low) rises at the detection edge, so within one microsecond tick. It stays high for exactly DRIVE0_US x CLK_PER_US cycles and then falls.
- R5: In a read slot with `tx_bit` = 1, `bus_pull` stays 0 for the whole slot.
- R6: In a read slot, `tx_taken` pulses for one cycle at the detection edge. `tx_bit` is captured at that edge, and later changes during the slot have no effect.
- R7: Falling edges that occur during an active slot, before its timed action, start no new slot and do not move its timing. Exactly one result comes out per slot.
- R8: `mode_rd` (1 = master read slot, 0 = master write slot) is sampled only at the detection edge. Changing it during a slot does not change the kind of slot.
- R9: With no falling edge on the bus, the block never pulls the bus and gives no strobe or acknowledge.
- R10: After the timed action, a new slot is accepted once the bus has been seen high again. Slots separated by a 2 us recovery each give a correct result.
- R11: `rx_valid` never pulses in a read slot, and `tx_taken` never pulses in a write slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 1 | Raw one-wire bus level (asynchronous) |
| mode_rd | input | 1 | Kind of the next slot: 1 = master read, 0 = master write |
| tx_bit | input | 1 | Bit to send in the next read slot |
| bus_pull | output | 1 | 1 = pull the bus low through an open-drain pad |
| rx_bit | output | 1 | Last bit received in a write slot |
| rx_valid | output | 1 | One-cycle strobe: `rx_bit` has been updated |
| tx_taken | output | 1 | One-cycle pulse: `tx_bit` was captured for a read slot |

## Verification
The hardest case to reach from the ports is a slot disturbed while it is in flight: a second falling edge before the sample point, or `mode_rd` and `tx_bit` flipping a few microseconds after the slot has started. The stimulus table holds vectors with a glitch pulse and a flip time measured from the slot start. Every result is then compared with the cycle offset counted from the first edge. A reset that arrives while the block is driving a 0 is applied directly, and the bench checks that the bus is released at once and that the next slot still works.

// File: rtl/owr_slot_pkg.sv
package owr_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_WRITE = 2'd1,
    SLOT_READ  = 2'd2,
    SLOT_DRAIN = 2'd3
  } slot_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owr_bus_sync.sv
module owr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_raw,
  output logic bus_s,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = bus_raw;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], bus_raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign bus_s = chain_q[STAGES-1];
  assign fall  = prev_q & ~bus_s;

endmodule

// File: rtl/owr_us_tick.sv
module owr_us_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int CNT_W = $clog2(CLK_PER_US + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_US - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/owr_us_timer.sv
module owr_us_timer #(
  parameter int US_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick,
  output logic [US_W-1:0] us_cnt
);

  logic [US_W-1:0] us_q;
  logic [US_W-1:0] us_d;
  logic            us_en;

  assign us_en = restart | (tick & ~(&us_q));

  always_comb begin
    if (restart) us_d = '0;
    else         us_d = us_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     us_q <= '0;
    else if (us_en) us_q <= us_d;
  end

  assign us_cnt = us_q;

endmodule

// File: rtl/owr_slot_fsm.sv
module owr_slot_fsm
  import owr_slot_pkg::*;
#(
  parameter int SAMPLE_US = 30,
  parameter int DRIVE0_US = 30,
  parameter int US_W      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall,
  input  logic            bus_s,
  input  logic            mode_rd,
  input  logic            tx_bit,
  input  logic            tick,
  input  logic [US_W-1:0] us_cnt,
  output logic            restart,
  output logic            bus_pull,
  output logic            rx_bit,
  output logic            rx_valid,
  output logic            tx_taken
);

  localparam logic [US_W-1:0] SAMPLE_LAST = US_W'(SAMPLE_US - 1);
  localparam logic [US_W-1:0] DRIVE_LAST  = US_W'(DRIVE0_US - 1);

  slot_state_e st_q, st_d;
  logic pull_q, pull_d;
  logic rxb_q, rxb_d;
  logic rxv_q, rxv_d;
  logic txt_q, txt_d;
  logic sample_now;
  logic drive_done;

  assign sample_now = tick && (us_cnt == SAMPLE_LAST);
  assign drive_done = tick && (us_cnt == DRIVE_LAST);

  always_comb begin
    st_d    = st_q;
    pull_d  = pull_q;
    rxb_d   = rxb_q;
    rxv_d   = 1'b0;
    txt_d   = 1'b0;
    restart = 1'b0;
    unique case (st_q)
      SLOT_IDLE: begin
        if (fall) begin
          restart = 1'b1;
          if (mode_rd) begin
            st_d   = SLOT_READ;
            pull_d = ~tx_bit;
            txt_d  = 1'b1;
          end else begin
            st_d = SLOT_WRITE;
          end
        end
      end
      SLOT_WRITE: begin
        if (sample_now) begin
          rxb_d = bus_s;
          rxv_d = 1'b1;
          st_d  = SLOT_DRAIN;
        end
      end
      SLOT_READ: begin
        if (drive_done) begin
          pull_d = 1'b0;
          st_d   = SLOT_DRAIN;
        end
      end
      SLOT_DRAIN: begin
        if (bus_s) st_d = SLOT_IDLE;
      end
      default: st_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_IDLE;
      pull_q <= 1'b0;
      rxb_q  <= 1'b0;
      rxv_q  <= 1'b0;
      txt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pull_q <= pull_d;
      rxb_q  <= rxb_d;
      rxv_q  <= rxv_d;
      txt_q  <= txt_d;
    end
  end

  assign bus_pull = pull_q;
  assign rx_bit   = rxb_q;
  assign rx_valid = rxv_q;
  assign tx_taken = txt_q;

endmodule

// File: rtl/owr_slot_resp.sv
module owr_slot_resp
  import owr_slot_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int SAMPLE_US   = 30,
  parameter int DRIVE0_US   = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic mode_rd,
  input  logic tx_bit,
  output logic bus_pull,
  output logic rx_bit,
  output logic rx_valid,
  output logic tx_taken
);

  localparam int SPAN_US = max_of(SAMPLE_US, DRIVE0_US);
  localparam int US_W    = $clog2(SPAN_US + 2);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            bus_s;
  logic            fall;
  logic            tick;
  logic            restart;
  logic [US_W-1:0] us_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  owr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bus_raw (bus_in),
    .bus_s   (bus_s),
    .fall    (fall)
  );

  owr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .tick    (tick)
  );

  owr_us_timer #(.US_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .tick    (tick),
    .us_cnt  (us_cnt)
  );

  owr_slot_fsm #(
    .SAMPLE_US (SAMPLE_US),
    .DRIVE0_US (DRIVE0_US),
    .US_W      (US_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fall     (fall),
    .bus_s    (bus_s),
    .mode_rd  (mode_rd),
    .tx_bit   (tx_bit),
    .tick     (tick),
    .us_cnt   (us_cnt),
    .restart  (restart),
    .bus_pull (bus_pull),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid),
    .tx_taken (tx_taken)
  );

endmodule

// File: rtl/owr_slot_resp_chk.sv
module owr_slot_resp_chk #(
  parameter int PULL_CYC = 6000
) (
  input logic clk,
  input logic rst_n,
  input logic bus_pull,
  input logic rx_valid,
  input logic tx_taken
);

  int unsigned pull_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pull_run_q <= 0;
    else if (bus_pull) pull_run_q <= pull_run_q + 1;
    else               pull_run_q <= 0;
  end

  a_r2_rx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_take_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> !tx_taken);

  a_r9_pull_with_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull) |-> tx_taken);

  a_r4_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pull_run_q <= PULL_CYC);

  a_r11_no_rx_while_pull: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull |-> !rx_valid);

  a_r11_rx_take_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_taken));

endmodule

bind owr_slot_resp owr_slot_resp_chk #(.PULL_CYC(DRIVE0_US * CLK_PER_US)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_pull (bus_pull),
  .rx_valid (rx_valid),
  .tx_taken (tx_taken)
);

// File: tb/owr_slot_resp_tb.sv
`timescale 1ns/1ps
module owr_slot_resp_tb_top;

  localparam int P      = 4;
  localparam int S_US   = 30;
  localparam int D_US   = 30;
  localparam int SLOT   = 70 * P;
  localparam int RX_AT  = 3 + S_US * P;
  localparam int NVEC   = 9;

  // fields: mode, txb, low_us[8], glitch_at_us[8], glitch_len_us[8], flip, exp_bit
  localparam logic [27:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 8'd60, 8'd0,  8'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'd5,  8'd0,  8'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'd1,  8'd0,  8'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'd1,  8'd0,  8'd0, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'd3,  8'd10, 8'd3, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'd40, 8'd0,  8'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'd1,  8'd0,  8'd0, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'd28, 8'd0,  8'd0, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'd31, 8'd0,  8'd0, 1'b0, 1'b0}
  };

  logic clk;
  logic rst_n;
  logic master_low;
  logic mode_rd;
  logic tx_bit;
  logic bus_in;
  logic bus_pull;
  logic rx_bit;
  logic rx_valid;
  logic tx_taken;

  int tests;
  int fails;
  bit done;

  int rx_n, rx_first, rx_val, tx_n, tx_first, pull_n, pull_first, pull_last;

  assign bus_in = ~(master_low | bus_pull);

  owr_slot_resp #(
    .CLK_PER_US (P),
    .SAMPLE_US  (S_US),
    .DRIVE0_US  (D_US)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .mode_rd  (mode_rd),
    .tx_bit   (tx_bit),
    .bus_pull (bus_pull),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid),
    .tx_taken (tx_taken)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int n);
    if (rx_valid) begin
      rx_n++;
      if (rx_first < 0) rx_first = n;
      rx_val = int'(rx_bit);
    end
    if (tx_taken) begin
      tx_n++;
      if (tx_first < 0) tx_first = n;
    end
    if (bus_pull) begin
      pull_n++;
      if (pull_first < 0) pull_first = n;
      pull_last = n;
    end
  endtask

  task automatic run_slot(input logic md, input logic tb_, input int low_us,
                          input int g_at, input int g_len, input logic flip);
    @(negedge clk);
    mode_rd    = md;
    tx_bit     = tb_;
    master_low = 1'b1;
    rx_n = 0; rx_first = -1; rx_val = -1; tx_n = 0; tx_first = -1;
    pull_n = 0; pull_first = -1; pull_last = -1;
    for (int n = 1; n <= SLOT; n++) begin
      @(negedge clk);
      observe(n);
      master_low = (n < low_us * P) ||
                   (g_len > 0 && n >= g_at * P && n < (g_at + g_len) * P);
      if (flip && n == 5 * P) begin
        mode_rd = ~md;
        tx_bit  = ~tb_;
      end
    end
    master_low = 1'b0;
    for (int n = SLOT + 1; n <= SLOT + 2 * P; n++) begin
      @(negedge clk);
      observe(n);
    end
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    master_low = 1'b0; mode_rd = 1'b0; tx_bit = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(bus_pull == 1'b0, "R1 pull in reset", int'(bus_pull), 0);
    check(rx_valid == 1'b0, "R1 rx_valid in reset", int'(rx_valid), 0);
    check(tx_taken == 1'b0, "R1 tx_taken in reset", int'(tx_taken), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R9: idle bus gives nothing
    rx_n = 0; rx_first = -1; tx_n = 0; tx_first = -1;
    pull_n = 0; pull_first = -1; pull_last = -1;
    for (int n = 1; n <= 50 * P; n++) begin
      @(negedge clk);
      observe(n);
    end
    check(pull_n == 0, "R9 idle pull", pull_n, 0);
    check(rx_n == 0, "R9 idle rx_valid", rx_n, 0);
    check(tx_n == 0, "R9 idle tx_taken", tx_n, 0);

    // table walk, back-to-back slots (R10)
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VECS[i];
      run_slot(v[27], v[26], int'(v[25:18]), int'(v[17:10]), int'(v[9:2]), v[1]);
      if (v[27] == 1'b0) begin
        check(rx_n == 1, $sformatf("R7 R10 vec%0d rx count", i), rx_n, 1);
        check(rx_first == RX_AT, $sformatf("R2 vec%0d rx cycle", i), rx_first, RX_AT);
        check(rx_val == int'(v[0]), $sformatf("R3 vec%0d rx bit", i), rx_val, int'(v[0]));
        check(tx_n == 0, $sformatf("R11 R8 vec%0d no take", i), tx_n, 0);
        check(pull_n == 0, $sformatf("R8 vec%0d no pull", i), pull_n, 0);
      end else begin
        check(tx_n == 1, $sformatf("R6 vec%0d take count", i), tx_n, 1);
        check(tx_first == 3, $sformatf("R6 vec%0d take cycle", i), tx_first, 3);
        check(rx_n == 0, $sformatf("R11 R8 vec%0d no rx", i), rx_n, 0);
        if (v[26] == 1'b0) begin
          check(pull_first == 3, $sformatf("R4 vec%0d pull start", i), pull_first, 3);
          check(pull_n == D_US * P, $sformatf("R4 R6 vec%0d pull length", i), pull_n, D_US * P);
          check(pull_last == 2 + D_US * P, $sformatf("R4 vec%0d pull end", i),
                pull_last, 2 + D_US * P);
        end else begin
          check(pull_n == 0, $sformatf("R5 vec%0d no pull", i), pull_n, 0);
        end
      end
    end

    // R1: reset while driving a 0 releases the bus at once
    @(negedge clk);
    mode_rd = 1'b1; tx_bit = 1'b0; master_low = 1'b1;
    repeat (4) @(negedge clk);
    master_low = 1'b0;
    repeat (20) @(negedge clk);
    check(bus_pull == 1'b1, "R4 pull mid slot", int'(bus_pull), 1);
    #1 rst_n = 1'b0;
    #1;
    check(bus_pull == 1'b0, "R1 async release", int'(bus_pull), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    run_slot(1'b0, 1'b1, 60, 0, 0, 1'b0);
    check(rx_n == 1 && rx_val == 0, "R1 R3 slot after reset", rx_val, 0);
    check(rx_first == RX_AT, "R2 slot after reset cycle", rx_first, RX_AT);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule